// File: doc/BRIEF.md
# GPIO Edge Interrupt and Wake Detector

This block watches a bank of already-synchronized general-purpose input pins and turns selected transitions into interrupt and wake events. Every pin has its own enable for rising transitions and its own enable for falling transitions on the interrupt path. A second pair of enables, held apart from the first, decides which transitions count as wake events. A pin with both enables set responds to either direction.

A qualifying transition sets a sticky pending bit. The interrupt path and the wake path each keep their own pending vector, and each drives a single output that stays high while any of its pending bits is set. Software clears pending bits with write-one-to-clear writes. A zero bit in the written word leaves that pin alone. If a new event lands in the same cycle as the clear of its bit, the event wins and the bit stays set. A small write port with a select code loads the four enable registers and issues the two clears. Address decoding of a wider register bus sits outside the block.

Top module: `pin_edge_irq_wake`

## Requirements
- R1: While `rst_n` is low, all four enable registers and both pending vectors are zero, and `irq_o` and `wake_o` are low.
- R2: A pin is sampled once per clock. A low-to-high change between two consecutive samples of pin k, while interrupt-rise enable bit k is 1 in that cycle, sets `irq_pend[k]` at that clock edge.
- R3: A high-to-low change on pin k, while interrupt-fall enable bit k is 1, sets `irq_pend[k]`. A pin with both enables set responds to both directions.
- R4: A transition whose matching enable bit is 0 sets no pending bit. A steady pin sets no pending bit whatever the enables hold.
- R5: Wake-rise and wake-fall enables set only `wake_pend`. Interrupt enables set only `irq_pend`. The two paths do not influence each other.
- R6: `irq_o` is high exactly while `irq_pend` is non-zero. `wake_o` is high exactly while `wake_pend` is non-zero.
- R7: A write with `cfg_sel` = 4 clears each `irq_pend` bit whose `cfg_wdata` bit is 1. A write with `cfg_sel` = 5 does the same for `wake_pend`. Bits written as 0 keep their value.
- R8: A qualifying transition on pin k in the same cycle as a clear of bit k leaves bit k set.
- R9: A write with `cfg_wr` = 1 loads `cfg_wdata` into one enable register at the clock edge, chosen by `cfg_sel`: 0 is interrupt-rise, 1 is interrupt-fall, 2 is wake-rise and 3 is wake-fall. The new value first qualifies transitions in the following cycle. A transition that happened before the enable was set is not captured afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NUM_PINS | Synchronized pin levels |
| cfg_wr | input | 1 | Write strobe for the enable registers and clears |
| cfg_sel | input | 3 | Target of the write: 0 to 3 are enables, 4 is interrupt clear, 5 is wake clear |
| cfg_wdata | input | NUM_PINS | Write data, one bit per pin |
| irq_pend | output | NUM_PINS | Pending interrupt vector |
| wake_pend | output | NUM_PINS | Pending wake vector |
| irq_o | output | 1 | Combined interrupt request |
| wake_o | output | 1 | Combined wake request |

## Verification
The bench aims at the race between a clear and a new event on the same bit. A design that gives the clear priority would drop that event and leave the bit low. It writes clear words with zero bits next to set pending bits. A plain register store in place of write-one-to-clear would wipe those neighbours. It drives transitions on pins whose matching enable is off, or whose only enable sits on the other path. A design with crossed enable registers or a shared pending vector would then raise the wrong output. It also sets an enable only after a pin has already changed. A design that compares against a stale sample, or that latches levels instead of transitions, would raise a late event. Pin 31 carries a wake event, which checks the top bit position.

// File: rtl/pew_pkg.sv
package pew_pkg;
   localparam int SEL_W = 3;

   typedef enum logic [SEL_W-1:0] {
      SEL_IRQ_RISE  = 3'd0,
      SEL_IRQ_FALL  = 3'd1,
      SEL_WAKE_RISE = 3'd2,
      SEL_WAKE_FALL = 3'd3,
      SEL_IRQ_CLR   = 3'd4,
      SEL_WAKE_CLR  = 3'd5
   } cfg_sel_e;

   localparam int NUM_MASKS = 4;
endpackage

// File: rtl/pew_edge_detect.sv
module pew_edge_detect #(
   parameter int NUM_PINS = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] rise,
   output logic [NUM_PINS-1:0] fall
);
   logic [NUM_PINS-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= pin_in;
   end

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      assign rise[i] = pin_in[i] & ~prev_q[i];
      assign fall[i] = ~pin_in[i] & prev_q[i];
   end
endmodule

// File: rtl/pew_mask_bank.sv
module pew_mask_bank
   import pew_pkg::*;
#(
   parameter int NUM_PINS = 32
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 cfg_wr,
   input  logic [SEL_W-1:0]                     cfg_sel,
   input  logic [NUM_PINS-1:0]                  cfg_wdata,
   output logic [NUM_MASKS-1:0][NUM_PINS-1:0]   masks
);
   for (genvar m = 0; m < NUM_MASKS; m++) begin : g_mask
      localparam logic [SEL_W-1:0] CODE = SEL_W'(m);
      logic [NUM_PINS-1:0] mask_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                         mask_q <= '0;
         else if (cfg_wr && cfg_sel == CODE) mask_q <= cfg_wdata;
      end
      assign masks[m] = mask_q;
   end
endmodule

// File: rtl/pew_sticky_status.sv
module pew_sticky_status #(
   parameter int NUM_PINS = 32,
   parameter bit OUT_REG  = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] set_vec,
   input  logic [NUM_PINS-1:0] clr_vec,
   output logic [NUM_PINS-1:0] pend,
   output logic                any
);
   logic [NUM_PINS-1:0] pend_q;
   logic [NUM_PINS-1:0] pend_d;

   // a new event outranks a clear of the same bit
   assign pend_d = (pend_q & ~clr_vec) | set_vec;

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_d;
   end

   assign pend = pend_q;

   if (OUT_REG) begin : g_any_reg
      logic any_q;
      always_ff @(posedge clk) begin
         if (!rst_n) any_q <= 1'b0;
         else        any_q <= |pend_d;
      end
      assign any = any_q;
   end else begin : g_any_comb
      assign any = |pend_q;
   end
endmodule

// File: rtl/pin_edge_irq_wake.sv
module pin_edge_irq_wake
   import pew_pkg::*;
#(
   parameter int NUM_PINS = 32,
   parameter bit OUT_REG  = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_in,
   input  logic                cfg_wr,
   input  logic [2:0]          cfg_sel,
   input  logic [NUM_PINS-1:0] cfg_wdata,
   output logic [NUM_PINS-1:0] irq_pend,
   output logic [NUM_PINS-1:0] wake_pend,
   output logic                irq_o,
   output logic                wake_o
);
   if (NUM_PINS < 1 || NUM_PINS > 1024) begin : g_bad_pins
      $error("pin_edge_irq_wake: NUM_PINS out of range");
   end

   logic [NUM_PINS-1:0]               rise;
   logic [NUM_PINS-1:0]               fall;
   logic [NUM_MASKS-1:0][NUM_PINS-1:0] masks;
   logic [NUM_PINS-1:0]               irq_hit;
   logic [NUM_PINS-1:0]               wake_hit;
   logic [NUM_PINS-1:0]               irq_clr;
   logic [NUM_PINS-1:0]               wake_clr;

   pew_edge_detect #(.NUM_PINS(NUM_PINS)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .rise(rise), .fall(fall)
   );

   pew_mask_bank #(.NUM_PINS(NUM_PINS)) u_masks (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .masks(masks)
   );

   assign irq_hit  = (rise & masks[SEL_IRQ_RISE])  | (fall & masks[SEL_IRQ_FALL]);
   assign wake_hit = (rise & masks[SEL_WAKE_RISE]) | (fall & masks[SEL_WAKE_FALL]);
   assign irq_clr  = (cfg_wr && cfg_sel == SEL_IRQ_CLR)  ? cfg_wdata : '0;
   assign wake_clr = (cfg_wr && cfg_sel == SEL_WAKE_CLR) ? cfg_wdata : '0;

   pew_sticky_status #(.NUM_PINS(NUM_PINS), .OUT_REG(OUT_REG)) u_irq_st (
      .clk(clk), .rst_n(rst_n), .set_vec(irq_hit), .clr_vec(irq_clr),
      .pend(irq_pend), .any(irq_o)
   );

   pew_sticky_status #(.NUM_PINS(NUM_PINS), .OUT_REG(OUT_REG)) u_wake_st (
      .clk(clk), .rst_n(rst_n), .set_vec(wake_hit), .clr_vec(wake_clr),
      .pend(wake_pend), .any(wake_o)
   );
endmodule

// File: rtl/pew_checker.sv
module pew_checker #(
   parameter int NUM_PINS = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cfg_wr,
   input logic [2:0]          cfg_sel,
   input logic [NUM_PINS-1:0] cfg_wdata,
   input logic [NUM_PINS-1:0] irq_pend,
   input logic [NUM_PINS-1:0] wake_pend,
   input logic                irq_o,
   input logic                wake_o,
   input logic [NUM_PINS-1:0] irq_hit,
   input logic [NUM_PINS-1:0] wake_hit,
   input logic [NUM_PINS-1:0] irq_en_any,
   input logic [NUM_PINS-1:0] wake_en_any
);
   logic [NUM_PINS-1:0] chk_iclr;
   logic [NUM_PINS-1:0] chk_wclr;
   assign chk_iclr = (cfg_wr && cfg_sel == 3'd4) ? cfg_wdata : '0;
   assign chk_wclr = (cfg_wr && cfg_sel == 3'd5) ? cfg_wdata : '0;

   // R1
   reset_clears_chk: assert property (@(posedge clk)
      !rst_n |=> (irq_pend == '0 && wake_pend == '0));

   // R4
   irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((irq_pend & ~$past(irq_pend) & ~$past(irq_en_any)) == '0));

   // R5
   wake_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((wake_pend & ~$past(wake_pend) & ~$past(wake_en_any)) == '0));

   // R7
   irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(irq_pend) & ~$past(chk_iclr) & ~irq_pend) == '0));

   // R7
   wake_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(wake_pend) & ~$past(chk_wclr) & ~wake_pend) == '0));

   // R8
   event_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(irq_hit) & ~irq_pend) == '0 && ($past(wake_hit) & ~wake_pend) == '0));

   // R6
   irq_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pend != '0 && chk_iclr == '0) |=> irq_o);

   // R6
   wake_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_pend != '0 && chk_wclr == '0) |=> wake_o);
endmodule

bind pin_edge_irq_wake pew_checker #(.NUM_PINS(NUM_PINS)) u_pew_chk (
   .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
   .cfg_wdata(cfg_wdata), .irq_pend(irq_pend), .wake_pend(wake_pend),
   .irq_o(irq_o), .wake_o(wake_o), .irq_hit(irq_hit), .wake_hit(wake_hit),
   .irq_en_any(masks[0] | masks[1]), .wake_en_any(masks[2] | masks[3])
);

// File: tb/test_pin_edge_irq_wake.sv
module test_pin_edge_irq_wake;
   localparam int N = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] pin_in = '0;
   logic         cfg_wr = 1'b0;
   logic [2:0]   cfg_sel = '0;
   logic [N-1:0] cfg_wdata = '0;
   logic [N-1:0] irq_pend, wake_pend;
   logic         irq_o, wake_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pin_edge_irq_wake #(.NUM_PINS(N)) i_pin_edge_irq_wake (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cfg_wr(cfg_wr),
      .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .irq_pend(irq_pend),
      .wake_pend(wake_pend), .irq_o(irq_o), .wake_o(wake_o)
   );

   typedef struct packed {
      logic [N-1:0] pin;
      logic         wr;
      logic [2:0]   sel;
      logic [N-1:0] wdata;
      logic [N-1:0] e_irq;
      logic [N-1:0] e_wake;
   } vec_t;

   // sel: 0 irq rise, 1 irq fall, 2 wake rise, 3 wake fall, 4 irq clear, 5 wake clear
   localparam vec_t VECS [14] = '{
      '{32'h0000_0000, 1'b1, 3'd0, 32'h0000_0003, 32'h0, 32'h0},          // R9 load
      '{32'h0000_0000, 1'b1, 3'd1, 32'h0000_0002, 32'h0, 32'h0},          // R9 load
      '{32'h0000_0000, 1'b1, 3'd2, 32'h8000_0000, 32'h0, 32'h0},          // R9 load
      '{32'h0000_0000, 1'b1, 3'd3, 32'h0000_0001, 32'h0, 32'h0},          // R9 load
      '{32'h0000_0001, 1'b0, 3'd0, 32'h0, 32'h0000_0001, 32'h0},          // R2 R5
      '{32'h0000_0003, 1'b0, 3'd0, 32'h0, 32'h0000_0003, 32'h0},          // R2
      '{32'h0000_0002, 1'b0, 3'd0, 32'h0, 32'h0000_0003, 32'h0000_0001},  // R5 R4
      '{32'h8000_0002, 1'b0, 3'd0, 32'h0, 32'h0000_0003, 32'h8000_0001},  // R5 top bit
      '{32'h8000_0002, 1'b1, 3'd4, 32'h0000_0001, 32'h0000_0002, 32'h8000_0001}, // R7
      '{32'h8000_0000, 1'b1, 3'd4, 32'h0000_0002, 32'h0000_0002, 32'h8000_0001}, // R8 R3
      '{32'h8000_0000, 1'b1, 3'd4, 32'hFFFF_FFFD, 32'h0000_0002, 32'h8000_0001}, // R7 zero bit
      '{32'h8000_0000, 1'b1, 3'd5, 32'h8000_0000, 32'h0000_0002, 32'h0000_0001}, // R7 wake
      '{32'h8000_0000, 1'b1, 3'd4, 32'h0000_0002, 32'h0, 32'h0000_0001},  // R7
      '{32'h8000_0000, 1'b1, 3'd5, 32'h0000_0001, 32'h0, 32'h0}           // R7 R6
   };

   task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(input logic [N-1:0] pin, input logic wr,
                       input logic [2:0] sel, input logic [N-1:0] wd);
      @(negedge clk);
      pin_in = pin; cfg_wr = wr; cfg_sel = sel; cfg_wdata = wd;
      @(posedge clk);
      #5;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #5;
      chk("R1 irq_pend", irq_pend, '0);
      chk("R1 wake_pend", wake_pend, '0);
      chk("R1 lines", {30'd0, irq_o, wake_o}, '0);
      @(negedge clk); rst_n = 1'b1;

      for (int i = 0; i < 14; i++) begin
         step(VECS[i].pin, VECS[i].wr, VECS[i].sel, VECS[i].wdata);
         chk("R2/R3/R5/R7/R8 irq_pend", irq_pend, VECS[i].e_irq);
         chk("R5/R7 wake_pend", wake_pend, VECS[i].e_wake);
         chk("R6 irq_o", {31'd0, irq_o}, {31'd0, VECS[i].e_irq != '0});
         chk("R6 wake_o", {31'd0, wake_o}, {31'd0, VECS[i].e_wake != '0});
      end

      // R4: rise on pin 0 with its rise enable off
      step(32'h8000_0000, 1'b1, 3'd0, 32'h0);
      step(32'h8000_0001, 1'b0, 3'd0, 32'h0);
      chk("R4 disabled edge", irq_pend, '0);
      // R9: enabling after the transition captures nothing
      step(32'h8000_0001, 1'b1, 3'd0, 32'h0000_0001);
      step(32'h8000_0001, 1'b0, 3'd0, 32'h0);
      chk("R9 late enable", irq_pend, '0);
      // R3: both enables on pin 2, both directions count
      step(32'h8000_0001, 1'b1, 3'd0, 32'h0000_0004);
      step(32'h8000_0001, 1'b1, 3'd1, 32'h0000_0004);
      step(32'h8000_0005, 1'b0, 3'd0, 32'h0);
      chk("R3 rise with both", irq_pend, 32'h0000_0004);
      step(32'h8000_0005, 1'b1, 3'd4, 32'h0000_0004);
      chk("R7 clear pin2", irq_pend, '0);
      step(32'h8000_0001, 1'b0, 3'd0, 32'h0);
      chk("R3 fall with both", irq_pend, 32'h0000_0004);
      // R1: reset mid-run clears state and enables
      @(negedge clk); rst_n = 1'b0; cfg_wr = 1'b0;
      @(posedge clk); #5;
      chk("R1 mid reset", irq_pend, '0);
      @(negedge clk); rst_n = 1'b1;
      step(32'h8000_0005, 1'b0, 3'd0, 32'h0);
      chk("R1 enables cleared", irq_pend | wake_pend, '0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule